// File: doc/BRIEF.md
# Dual-CPU Data Mover Command Register

This block is the 32-bit command and status register through which either of two CPUs starts a transfer on a shared data mover. Each CPU has its own write and read port. A write with the command-valid bit set starts a transfer, but only when no transfer is already running. The block then records which CPU issued it, raises a one-cycle start pulse to the mover, and tracks the running and finished status until the CPU that started the transfer acknowledges it.

The CPU that started the transfer owns the register. The other CPU sees the status flags as zero. While the finished flag is set, nothing the other CPU writes has any effect. Configuration bits also produce two registered override controls for transfer address bits 3 and 4. These controls send the transfer to one or both memory channels, either as fixed forces or interleaved on transfer address bit 6.

Top module: `dmc_cmd_csr`

## Requirements
- R1: After reset every stored field is zero. Reads from both CPUs return 0x00000000, and `mv_start`, `adr3_force` and `adr4_force` are low.
- R2: A write with bit 11 = 1, accepted while bit 30 is clear, starts a transfer. It sets bit 30 (running) and bit 11 (command valid), and stores the writer in bit 16 (1 = CPU1, 0 = CPU0). `mv_start` is high for exactly the one cycle that follows the write.
- R3: A write with bit 11 = 1 while bit 30 is set raises no start pulse. It does not change bit 16 or bit 11.
- R4: A `mv_done` pulse while bit 30 is set clears bit 30 and sets bit 31 (finished).
- R5: Bit 31 is write-one-to-clear, and only the owner can clear it. Writing 0 to bit 31 leaves it unchanged.
- R6: While bit 31 is set, a write from the CPU not named in bit 16 changes no field.
- R7: Reads by the CPU not named in bit 16 return zero in bits 31 and 30. The owner reads their true values.
- R8: A read returns the current value of bit 11 and then clears it.
- R9: Bits 29:17, 15, 14, 13, 12 and 10 store the written value. Bits 9:0 always read zero. Bit 16 cannot be written directly.
- R10: Bit 13 forces `adr4_force` high and bit 12 forces `adr3_force` high, from the cycle after the register changes.
- R11: With bit 14 set, `adr3_force` follows transfer address bit 6 and `adr4_force` follows its inverse, registered one cycle.
- R12: When both CPUs write in the same cycle, the CPU0 write is applied at once. The CPU1 write is held and applied in the next cycle without a CPU0 write. A newer CPU1 write replaces one that is still held.
- R13: `cpu_rvld[c]` and `cpu_rdataC` appear one cycle after `cpu_rd[c]`. Both CPUs may read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 2 | Write strobe per CPU (bit c = CPU c) |
| cpu_wdata0 | input | 32 | CPU0 write data |
| cpu_wdata1 | input | 32 | CPU1 write data |
| cpu_rd | input | 2 | Read strobe per CPU |
| cpu_rvld | output | 2 | Read data valid per CPU |
| cpu_rdata0 | output | 32 | CPU0 readback |
| cpu_rdata1 | output | 32 | CPU1 readback |
| mv_done | input | 1 | Completion pulse from the data mover |
| xfer_addr | input | AW | Current transfer address |
| mv_start | output | 1 | One-cycle start pulse to the data mover |
| adr3_force | output | 1 | Override for transfer address bit 3 |
| adr4_force | output | 1 | Override for transfer address bit 4 |

## Verification
The hardest state to reach is a collision in which a CPU1 write is held and then replaced before it is applied. Reaching it needs CPU0 to write in two consecutive cycles while CPU1 writes different data in both. The bench drives exactly that pattern and reads back the value that survives. Ownership masking and the lock need a full transfer started by CPU1, so that CPU0 is the non-owner. The bench then sends a completion pulse and attempts a clear from CPU0 before CPU1 clears the finished flag itself.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam int DW   = 32;
  localparam int NCPU = 2;

  // Bit positions decoded by software
  localparam int B_DONE  = 31;
  localparam int B_BUSY  = 30;
  localparam int B_OWNER = 16;
  localparam int B_ILV   = 14;
  localparam int B_F4    = 13;
  localparam int B_F3    = 12;
  localparam int B_CMDV  = 11;

  // Plain read/write storage: reserved fields plus steering controls
  localparam logic [DW-1:0] RW_MASK = 32'h3FFE_0000 | 32'h0000_8000 |
                                      32'h0000_7000 | 32'h0000_0400;

  typedef struct packed {
    logic          vld;
    logic          cpu;
    logic [DW-1:0] data;
  } dmc_wr_t;

  typedef struct packed {
    logic          done;
    logic          busy;
    logic          owner;
    logic          cmdv;
    logic [DW-1:0] cfg;
  } dmc_state_t;
endpackage

// File: rtl/dmc_wr_arb.sv
module dmc_wr_arb
  import dmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NCPU-1:0] wr_vld,
  input  logic [DW-1:0]   wr_data0,
  input  logic [DW-1:0]   wr_data1,
  output dmc_wr_t         sel
);
  logic          hold_vld;
  logic [DW-1:0] hold_data;

  // CPU0 first; a fresh CPU1 write supersedes a held one
  always_comb begin
    sel = '0;
    if (wr_vld[0]) begin
      sel.vld  = 1'b1;
      sel.cpu  = 1'b0;
      sel.data = wr_data0;
    end else if (wr_vld[1]) begin
      sel.vld  = 1'b1;
      sel.cpu  = 1'b1;
      sel.data = wr_data1;
    end else if (hold_vld) begin
      sel.vld  = 1'b1;
      sel.cpu  = 1'b1;
      sel.data = hold_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else if (wr_vld[0] && wr_vld[1]) begin
      hold_vld  <= 1'b1;
      hold_data <= wr_data1;
    end else if (!wr_vld[0]) begin
      hold_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/dmc_core.sv
module dmc_core
  import dmc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  dmc_wr_t         sel,
  input  logic            cmp,
  input  logic [NCPU-1:0] rd_req,
  output dmc_state_t      st,
  output logic            start
);
  logic       acc;
  logic       go;
  dmc_state_t nx;

  always_comb begin
    acc = sel.vld && !(st.done && (sel.cpu != st.owner));
    go  = acc && sel.data[B_CMDV] && !st.busy;
    nx  = st;
    if (st.busy && cmp)                nx.done = 1'b1;
    else if (acc && sel.data[B_DONE])  nx.done = 1'b0;
    if (go)                            nx.busy = 1'b1;
    else if (cmp)                      nx.busy = 1'b0;
    if (go)                            nx.owner = sel.cpu;
    if (go)                            nx.cmdv = 1'b1;
    else if (|rd_req)                  nx.cmdv = 1'b0;
    if (acc)                           nx.cfg = sel.data & RW_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '0;
      start <= 1'b0;
    end else begin
      st    <= nx;
      start <= go;
    end
  end
endmodule

// File: rtl/dmc_rd_port.sv
module dmc_rd_port
  import dmc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  dmc_state_t               st,
  input  logic [NCPU-1:0]          rd_req,
  output logic [NCPU-1:0]          rd_vld,
  output logic [NCPU-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] word;

  always_comb begin
    word          = st.cfg;
    word[B_DONE]  = st.done;
    word[B_BUSY]  = st.busy;
    word[B_OWNER] = st.owner;
    word[B_CMDV]  = st.cmdv;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_port
    logic          is_owner;
    logic [DW-1:0] view;

    always_comb begin
      is_owner = (st.owner == c[0]);
      view     = word;
      if (!is_owner) begin
        view[B_DONE] = 1'b0;
        view[B_BUSY] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_vld[c]  <= 1'b0;
        rd_data[c] <= '0;
      end else begin
        rd_vld[c] <= rd_req[c];
        if (rd_req[c]) rd_data[c] <= view;
      end
    end
  end
endmodule

// File: rtl/dmc_steer.sv
module dmc_steer
  import dmc_pkg::*;
#(
  parameter int AW      = 40,
  parameter int ILV_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg,
  input  logic [AW-1:0] addr,
  output logic          ovr3,
  output logic          ovr4
);
  logic hi;
  assign hi = addr[ILV_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr3 <= 1'b0;
      ovr4 <= 1'b0;
    end else begin
      ovr3 <= cfg[B_F3] | (cfg[B_ILV] &  hi);
      ovr4 <= cfg[B_F4] | (cfg[B_ILV] & ~hi);
    end
  end
endmodule

// File: rtl/dmc_cmd_csr.sv
module dmc_cmd_csr
  import dmc_pkg::*;
#(
  parameter int AW      = 40,
  parameter int ILV_BIT = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cpu_wr,
  input  logic [31:0]   cpu_wdata0,
  input  logic [31:0]   cpu_wdata1,
  input  logic [1:0]    cpu_rd,
  output logic [1:0]    cpu_rvld,
  output logic [31:0]   cpu_rdata0,
  output logic [31:0]   cpu_rdata1,
  input  logic          mv_done,
  input  logic [AW-1:0] xfer_addr,
  output logic          mv_start,
  output logic          adr3_force,
  output logic          adr4_force
);
  dmc_wr_t                   sel;
  dmc_state_t                st;
  logic [NCPU-1:0][DW-1:0]   rdata;

  dmc_wr_arb u_arb (
    .clk(clk), .rst(rst), .wr_vld(cpu_wr),
    .wr_data0(cpu_wdata0), .wr_data1(cpu_wdata1), .sel(sel)
  );

  dmc_core u_core (
    .clk(clk), .rst(rst), .sel(sel), .cmp(mv_done),
    .rd_req(cpu_rd), .st(st), .start(mv_start)
  );

  dmc_rd_port u_rd (
    .clk(clk), .rst(rst), .st(st), .rd_req(cpu_rd),
    .rd_vld(cpu_rvld), .rd_data(rdata)
  );

  dmc_steer #(.AW(AW), .ILV_BIT(ILV_BIT)) u_steer (
    .clk(clk), .rst(rst), .cfg(st.cfg), .addr(xfer_addr),
    .ovr3(adr3_force), .ovr4(adr4_force)
  );

  assign cpu_rdata0 = rdata[0];
  assign cpu_rdata1 = rdata[1];
endmodule

// File: rtl/dmc_cmd_csr_chk.sv
module dmc_cmd_csr_chk
  import dmc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input dmc_state_t st,
  input dmc_wr_t    sel,
  input logic       mv_done,
  input logic       mv_start,
  input logic [1:0] cpu_rd,
  input logic [1:0] cpu_rvld,
  input logic [31:0] cpu_rdata0,
  input logic [31:0] cpu_rdata1,
  input logic       adr3_force,
  input logic       adr4_force
);
  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    mv_start |=> !mv_start);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    mv_start |-> st.busy);

  p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
    $past(st.busy) |-> !mv_start);

  p_cmp_done_r4: assert property (@(posedge clk) disable iff (rst)
    (st.busy && mv_done) |=> (st.done && !st.busy));

  p_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (st.done && sel.vld && (sel.cpu != st.owner) && !(st.busy && mv_done))
      |=> ($stable(st.cfg) && $stable(st.owner) && st.done));

  p_mask0_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvld[0] && $past(st.owner)) |-> (cpu_rdata0[31:30] == 2'b00));

  p_mask1_r7: assert property (@(posedge clk) disable iff (rst)
    (cpu_rvld[1] && !$past(st.owner)) |-> (cpu_rdata1[31:30] == 2'b00));

  p_ilv_r11: assert property (@(posedge clk) disable iff (rst)
    $past(st.cfg[B_ILV] && !st.cfg[B_F3] && !st.cfg[B_F4])
      |-> (adr3_force != adr4_force));

  p_rd_lat_r13: assert property (@(posedge clk) disable iff (rst)
    cpu_rvld == $past(cpu_rd));
endmodule

bind dmc_cmd_csr dmc_cmd_csr_chk u_chk (
  .clk(clk), .rst(rst), .st(st), .sel(sel), .mv_done(mv_done),
  .mv_start(mv_start), .cpu_rd(cpu_rd), .cpu_rvld(cpu_rvld),
  .cpu_rdata0(cpu_rdata0), .cpu_rdata1(cpu_rdata1),
  .adr3_force(adr3_force), .adr4_force(adr4_force)
);

// File: tb/test_dmc_cmd_csr.sv
module test_dmc_cmd_csr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 40;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    cpu_wr, cpu_rd, cpu_rvld;
  logic [31:0]   cpu_wdata0, cpu_wdata1, cpu_rdata0, cpu_rdata1;
  logic          mv_done, mv_start, adr3_force, adr4_force;
  logic [AW-1:0] xfer_addr;

  int nchk = 0;
  int nerr = 0;
  bit ended = 0;

  logic [31:0] exp_q0[$];
  logic [31:0] exp_q1[$];
  string       tag_q0[$];
  string       tag_q1[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_cmd_csr #(.AW(AW)) i_dmc_cmd_csr (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_wdata0(cpu_wdata0),
    .cpu_wdata1(cpu_wdata1), .cpu_rd(cpu_rd), .cpu_rvld(cpu_rvld),
    .cpu_rdata0(cpu_rdata0), .cpu_rdata1(cpu_rdata1), .mv_done(mv_done),
    .xfer_addr(xfer_addr), .mv_start(mv_start), .adr3_force(adr3_force),
    .adr4_force(adr4_force)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int c, input logic [31:0] d);
    if (c == 0) cpu_wdata0 = d; else cpu_wdata1 = d;
    cpu_wr[c] = 1'b1;
    step();
    cpu_wr = 2'b00;
  endtask

  task automatic rd(input int c, input logic [31:0] exp, input string tag);
    if (c == 0) begin exp_q0.push_back(exp); tag_q0.push_back(tag); end
    else        begin exp_q1.push_back(exp); tag_q1.push_back(tag); end
    cpu_rd[c] = 1'b1;
    step();
    cpu_rd = 2'b00;
  endtask

  // Monitor: compare read responses against the scoreboard queues
  always @(negedge clk) begin
    if (!rst && cpu_rvld[0]) begin
      if (exp_q0.size() == 0) chk("R13 unexpected cpu0 read", 32'd1, 32'd0);
      else chk(tag_q0.pop_front(), cpu_rdata0, exp_q0.pop_front());
    end
    if (!rst && cpu_rvld[1]) begin
      if (exp_q1.size() == 0) chk("R13 unexpected cpu1 read", 32'd1, 32'd0);
      else chk(tag_q1.pop_front(), cpu_rdata1, exp_q1.pop_front());
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; cpu_wr = '0; cpu_rd = '0; cpu_wdata0 = '0; cpu_wdata1 = '0;
    mv_done = 1'b0; xfer_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 start", {31'd0, mv_start}, 0);
    chk("R1 overrides", {30'd0, adr3_force, adr4_force}, 0);
    rd(0, 32'h0, "R1 cpu0 read");
    rd(1, 32'h0, "R1 cpu1 read");

    // R2 start from CPU0
    wr(0, 32'h0000_0800);
    chk("R2 start pulse", {31'd0, mv_start}, 1);
    step();
    chk("R2 single-cycle start", {31'd0, mv_start}, 0);
    rd(0, 32'h4000_0800, "R2 owner read");
    rd(0, 32'h4000_0000, "R8 command valid cleared by read");
    rd(1, 32'h0000_0000, "R7 non-owner busy masked");

    // R3 start while running
    wr(1, 32'h0000_0800);
    chk("R3 no start while running", {31'd0, mv_start}, 0);
    rd(0, 32'h4000_0000, "R3 owner and command valid unchanged");

    // R4 completion
    mv_done = 1'b1; step(); mv_done = 1'b0;
    rd(0, 32'h8000_0000, "R4 done set busy clear");
    rd(1, 32'h0000_0000, "R7 non-owner done masked");

    // R6 lock against CPU1
    wr(1, 32'h8000_7000);
    step();
    chk("R6 overrides untouched", {30'd0, adr3_force, adr4_force}, 0);
    rd(0, 32'h8000_0000, "R6 locked register unchanged");

    // R5 write-one-to-clear
    wr(0, 32'h0000_0000);
    rd(0, 32'h8000_0000, "R5 writing zero keeps done");
    wr(0, 32'h8000_0000);
    rd(0, 32'h0000_0000, "R5 writing one clears done");

    // R9 field storage
    wr(1, 32'h3FFF_F7FF);
    rd(1, 32'h3FFE_F400, "R9 stored fields");
    step();
    chk("R10 both forces", {30'd0, adr3_force, adr4_force}, 32'd3);

    // R10 individual forces
    wr(0, 32'h0000_2000);
    step();
    chk("R10 bit13 drives adr4", {30'd0, adr3_force, adr4_force}, 32'd1);
    wr(0, 32'h0000_1000);
    step();
    chk("R10 bit12 drives adr3", {30'd0, adr3_force, adr4_force}, 32'd2);

    // R11 interleave
    wr(0, 32'h0000_4000);
    xfer_addr = 40'h40;
    step();
    chk("R11 addr6 high selects adr3", {30'd0, adr3_force, adr4_force}, 32'd2);
    xfer_addr = 40'h80;
    step();
    chk("R11 addr6 low selects adr4", {30'd0, adr3_force, adr4_force}, 32'd1);

    // R2/R7/R6 with CPU1 as owner
    wr(1, 32'h0000_4800);
    chk("R2 cpu1 start pulse", {31'd0, mv_start}, 1);
    rd(1, 32'h4001_4800, "R2 cpu1 owner recorded");
    rd(0, 32'h0001_4000, "R7 cpu0 non-owner masked");
    mv_done = 1'b1; step(); mv_done = 1'b0;
    wr(0, 32'h8000_0000);
    rd(1, 32'h8001_4000, "R6 cpu0 cannot clear cpu1 done");
    wr(1, 32'h8000_0000);
    rd(1, 32'h0001_0000, "R5 owner cpu1 clears done");

    // R12 collision
    cpu_wdata0 = 32'h0000_2000; cpu_wdata1 = 32'h0000_1000;
    cpu_wr = 2'b11;
    step();
    cpu_wr = 2'b00;
    rd(0, 32'h0001_2000, "R12 cpu0 served first");
    rd(0, 32'h0001_1000, "R12 held cpu1 applied next");

    // R12 replacement of a held write
    cpu_wdata0 = 32'h0000_2000; cpu_wdata1 = 32'h0000_4000;
    cpu_wr = 2'b11;
    step();
    cpu_wdata1 = 32'h0000_3000;
    step();
    cpu_wr = 2'b00;
    step();
    // R13 simultaneous reads
    exp_q0.push_back(32'h0001_3000); tag_q0.push_back("R12 newer held write wins");
    exp_q1.push_back(32'h0001_3000); tag_q1.push_back("R13 dual read cpu1");
    cpu_rd = 2'b11;
    step();
    cpu_rd = 2'b00;
    step();

    chk("R13 cpu0 responses pending", exp_q0.size(), 0);
    chk("R13 cpu1 responses pending", exp_q1.size(), 0);
    finish_run();
  end
endmodule